// File: doc/BRIEF.md
# Multibank DRAM Command Tracker

This block sits beside a DRAM controller's command issue stage and keeps a record of every bank of an eight-bank device. A command (activate, read, write or precharge) arrives each clock, together with a bank number and a row or column address. The tracker decides whether the command is legal against the recorded bank state. It reports the verdict one cycle later and keeps the record in step with what the device itself would do. That record includes the self-timed close that follows a read or write issued with the auto-precharge flag.

Each bank runs its own small state machine with three states. In BK_IDLE no row is open. BK_OPEN means a row is open and accepts bursts. BK_AUTOCLOSE means an auto-precharge burst is running and the bank closes itself when it ends. The transitions have names. *open* (BK_IDLE to BK_OPEN) happens on a legal activate. *close* (BK_OPEN to BK_IDLE) happens on a precharge. *arm* (BK_OPEN to BK_AUTOCLOSE) happens on a read or write with auto-precharge. *expire* (BK_AUTOCLOSE to BK_IDLE) happens when the burst countdown reaches its last beat. The burst occupies 2 clocks at burst length 4 and 4 clocks at burst length 8. A read or write also reports its burst column with the two lowest bits cleared.

Top module: `bank_cmd_tracker`

## Requirements
- R1: After reset all banks are closed (`bank_open` = 0). `cmd_ok`, `cmd_err`, `acc_valid` and `ap_close` are all 0.
- R2: An activate (`cmd_op` = 1) to a bank in BK_IDLE is legal. `cmd_ok` pulses in the cycle after the sampling edge. The bank's `bank_open` bit rises in that same cycle, and its slice of `open_rows` (bits b*12 to b*12+11) holds `cmd_row`.
- R3: An activate to a bank in BK_OPEN or BK_AUTOCLOSE is illegal. `cmd_err` pulses for one cycle, and no bank state or recorded row changes.
- R4: A read (`cmd_op` = 2) or write (`cmd_op` = 3) is legal only to a bank in BK_OPEN. Sent to a bank in BK_IDLE or BK_AUTOCLOSE, it pulses `cmd_err` and changes nothing.
- R5: A legal read or write sets `acc_valid` for one cycle. In that cycle `acc_col` equals `cmd_col` with bits 1:0 forced to zero.
- R6: A legal read or write with `cmd_ap` = 1 moves the bank to BK_AUTOCLOSE. Take the command's sampling edge as t. With `cmd_bl8` = 0 (burst of 4), the bank closes at edge t+2. With `cmd_bl8` = 1 (burst of 8), it closes at edge t+4. In the cycle after the closing edge, the bank's `bank_open` bit is 0 and its `ap_close` bit is 1 for exactly one cycle.
- R7: A precharge (`cmd_op` = 4) is always legal (`cmd_ok`). It closes a bank in BK_OPEN and has no effect on a bank in BK_IDLE or BK_AUTOCLOSE.
- R8: Banks are independent. Commands to other banks are judged and applied normally while a bank is in BK_AUTOCLOSE.
- R9: A no-operation (`cmd_op` = 0) raises neither `cmd_ok` nor `cmd_err`. The codes 5, 6 and 7 are illegal (`cmd_err`) and change no state.
- R10: `cmd_ok` and `cmd_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_ap | input | 1 | Auto-precharge flag for read/write |
| cmd_bl8 | input | 1 | Burst length: 0 = 4, 1 = 8 |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | 12 | Row address for activate |
| cmd_col | input | 9 | Column address for read/write |
| cmd_ok | output | 1 | Previous command was legal |
| cmd_err | output | 1 | Previous command was illegal |
| acc_valid | output | 1 | Previous command was a legal read/write |
| acc_col | output | 9 | Burst start column, low two bits zero |
| bank_open | output | 8 | Per-bank row-open flag |
| open_rows | output | 96 | Recorded row per bank, 12 bits each |
| ap_close | output | 8 | Per-bank pulse on self-timed close |

## Verification
The verdict, `acc_valid`/`acc_col`, the opening or closing by a command, and the recorded row all appear one cycle after the sampling edge. A self-timed close appears 2 or 4 edges after the arming edge, plus the output register. The bench drives each command at a falling edge and runs a model that advances once per command edge, so every queued expectation already includes any close due at that edge. The monitor pops and compares one expectation 5 ns after each rising edge, well clear of the edges where inputs change.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_ACT   = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_PRE   = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        BK_IDLE      = 2'd0,
        BK_OPEN      = 2'd1,
        BK_AUTOCLOSE = 2'd2
    } bank_st_e;

    localparam int BL4_CLKS = 2;
    localparam int BL8_CLKS = 4;
    localparam int CNT_W    = $clog2(BL8_CLKS + 1);

endpackage

// File: rtl/bank_trk_decode.sv
module bank_trk_decode
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic [2:0]           op,
    input  logic [BANK_W-1:0]    bank,
    input  logic [NUM_BANKS-1:0] is_idle,
    input  logic [NUM_BANKS-1:0] is_open,
    output logic                 legal,
    output logic                 illegal,
    output logic                 rw_legal,
    output logic [NUM_BANKS-1:0] act_sel,
    output logic [NUM_BANKS-1:0] rw_sel,
    output logic [NUM_BANKS-1:0] pre_sel
);

    logic [NUM_BANKS-1:0] onehot;
    logic                 tgt_idle;
    logic                 tgt_open;

    always_comb begin
        onehot   = NUM_BANKS'(1) << bank;
        tgt_idle = is_idle[bank];
        tgt_open = is_open[bank];
        legal    = 1'b0;
        illegal  = 1'b0;
        rw_legal = 1'b0;
        act_sel  = '0;
        rw_sel   = '0;
        pre_sel  = '0;
        unique case (cmd_op_e'(op))
            OP_NOP: ;
            OP_ACT: begin
                legal   = tgt_idle;
                illegal = !tgt_idle;
                act_sel = tgt_idle ? onehot : '0;
            end
            OP_READ, OP_WRITE: begin
                legal    = tgt_open;
                illegal  = !tgt_open;
                rw_legal = tgt_open;
                rw_sel   = tgt_open ? onehot : '0;
            end
            OP_PRE: begin
                legal   = 1'b1;
                pre_sel = onehot;
            end
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/bank_trk_fsm.sv
module bank_trk_fsm
    import bank_trk_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             rw_go,
    input  logic             rw_ap,
    input  logic             rw_bl8,
    input  logic             pre_go,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_idle,
    output logic             is_open,
    output logic             is_live,
    output logic [ROW_W-1:0] row_q,
    output logic             close_pulse
);

    bank_st_e         state_q;
    bank_st_e         state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_beat;

    assign last_beat = (cnt_q == CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    // transitions: open, close, arm, expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE:      if (act_go) state_d = BK_OPEN;
            BK_OPEN: begin
                if (pre_go)              state_d = BK_IDLE;
                else if (rw_go && rw_ap) state_d = BK_AUTOCLOSE;
            end
            BK_AUTOCLOSE: if (last_beat) state_d = BK_IDLE;
            default:      state_d = BK_IDLE;
        endcase
    end

    // registered outputs: row record, burst countdown, close pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q       <= '0;
            cnt_q       <= '0;
            close_pulse <= 1'b0;
        end else begin
            close_pulse <= 1'b0;
            if (state_q == BK_IDLE && act_go) row_q <= act_row;
            unique case (state_q)
                BK_OPEN: if (rw_go && rw_ap && !pre_go)
                    cnt_q <= rw_bl8 ? CNT_W'(BL8_CLKS) : CNT_W'(BL4_CLKS);
                BK_AUTOCLOSE: begin
                    cnt_q       <= cnt_q - CNT_W'(1);
                    close_pulse <= last_beat;
                end
                default: ;
            endcase
        end
    end

    assign is_idle = (state_q == BK_IDLE);
    assign is_open = (state_q == BK_OPEN);
    assign is_live = (state_q != BK_IDLE);

endmodule

// File: rtl/bank_cmd_tracker.sv
module bank_cmd_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 cmd_op,
    input  logic                       cmd_ap,
    input  logic                       cmd_bl8,
    input  logic [BANK_W-1:0]          cmd_bank,
    input  logic [ROW_W-1:0]           cmd_row,
    input  logic [COL_W-1:0]           cmd_col,
    output logic                       cmd_ok,
    output logic                       cmd_err,
    output logic                       acc_valid,
    output logic [COL_W-1:0]           acc_col,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [NUM_BANKS-1:0]       ap_close
);

    localparam logic [COL_W-1:0] COL_MASK = ~COL_W'(3);

    logic [NUM_BANKS-1:0] is_idle;
    logic [NUM_BANKS-1:0] is_open;
    logic [NUM_BANKS-1:0] act_sel;
    logic [NUM_BANKS-1:0] rw_sel;
    logic [NUM_BANKS-1:0] pre_sel;
    logic                 legal;
    logic                 illegal;
    logic                 rw_legal;

    bank_trk_decode #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W)
    ) u_decode (
        .op      (cmd_op),
        .bank    (cmd_bank),
        .is_idle (is_idle),
        .is_open (is_open),
        .legal   (legal),
        .illegal (illegal),
        .rw_legal(rw_legal),
        .act_sel (act_sel),
        .rw_sel  (rw_sel),
        .pre_sel (pre_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_trk_fsm #(.ROW_W(ROW_W)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_go     (act_sel[b]),
            .rw_go      (rw_sel[b]),
            .rw_ap      (cmd_ap),
            .rw_bl8     (cmd_bl8),
            .pre_go     (pre_sel[b]),
            .act_row    (cmd_row),
            .is_idle    (is_idle[b]),
            .is_open    (is_open[b]),
            .is_live    (bank_open[b]),
            .row_q      (open_rows[b*ROW_W +: ROW_W]),
            .close_pulse(ap_close[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ok    <= 1'b0;
            cmd_err   <= 1'b0;
            acc_valid <= 1'b0;
            acc_col   <= '0;
        end else begin
            cmd_ok    <= legal;
            cmd_err   <= illegal;
            acc_valid <= rw_legal;
            if (rw_legal) acc_col <= cmd_col & COL_MASK;
        end
    end

endmodule

// File: rtl/bank_cmd_tracker_chk.sv
module bank_cmd_tracker_chk #(
    parameter int NUM_BANKS = 8,
    parameter int COL_W     = 9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_ok,
    input logic                 cmd_err,
    input logic                 acc_valid,
    input logic [COL_W-1:0]     acc_col,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic [NUM_BANKS-1:0] ap_close
);

    // R10
    verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_err));

    // R5
    col_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (acc_col[1:0] == 2'b00));

    // R4
    access_is_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> cmd_ok);

    // R2
    open_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bank_open & ~$past(bank_open)) != '0) |-> cmd_ok);

    // R3
    err_opens_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> ((bank_open & ~$past(bank_open)) == '0));

    // R6
    close_leaves_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_close != '0) |-> (((ap_close & bank_open) == '0) &&
                              (($past(bank_open) & ap_close) == ap_close)));

endmodule

bind bank_cmd_tracker bank_cmd_tracker_chk #(
    .NUM_BANKS(NUM_BANKS),
    .COL_W    (COL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ok   (cmd_ok),
    .cmd_err  (cmd_err),
    .acc_valid(acc_valid),
    .acc_col  (acc_col),
    .bank_open(bank_open),
    .ap_close (ap_close)
);

// File: tb/bank_cmd_tracker_bench.sv
`timescale 1ns/1ps
module bank_cmd_tracker_bench;

    localparam int NB = 8;
    localparam int RW = 12;
    localparam int CW = 9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     cmd_op = '0;
    logic           cmd_ap = 1'b0;
    logic           cmd_bl8 = 1'b0;
    logic [2:0]     cmd_bank = '0;
    logic [RW-1:0]  cmd_row = '0;
    logic [CW-1:0]  cmd_col = '0;
    logic           cmd_ok, cmd_err, acc_valid;
    logic [CW-1:0]  acc_col;
    logic [NB-1:0]  bank_open, ap_close;
    logic [NB*RW-1:0] open_rows;

    bank_cmd_tracker u_bank_cmd_tracker (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ap(cmd_ap),
        .cmd_bl8(cmd_bl8), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_ok(cmd_ok), .cmd_err(cmd_err),
        .acc_valid(acc_valid), .acc_col(acc_col), .bank_open(bank_open),
        .open_rows(open_rows), .ap_close(ap_close)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic          ok, err, av;
        logic [CW-1:0] col;
        logic [NB-1:0] open, close;
        logic [NB*RW-1:0] rows;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    // model: 0 closed, 1 open, 2 auto-closing
    int            m_st [NB];
    logic [RW-1:0] m_row[NB];
    int            m_cnt[NB];

    task automatic issue(input logic [2:0] op, input int bk, input logic [RW-1:0] row,
                         input logic [CW-1:0] col, input logic ap, input logic bl8,
                         input string tag);
        exp_t e;
        @(negedge clk);
        cmd_op = op; cmd_bank = 3'(bk); cmd_row = row; cmd_col = col;
        cmd_ap = ap; cmd_bl8 = bl8;
        e.ok = 0; e.err = 0; e.av = 0; e.col = 'x; e.close = '0;
        // self-timed closes due at this edge
        for (int b = 0; b < NB; b++) begin
            if (m_st[b] == 2) begin
                if (m_cnt[b] == 1) begin m_st[b] = 0; e.close[b] = 1'b1; end
                else m_cnt[b] = m_cnt[b] - 1;
            end
        end
        // command (targets of an auto-closing bank are unaffected either way)
        case (op)
            3'd0: ;
            3'd1: if (m_st[bk] == 0 && !e.close[bk]) begin
                      e.ok = 1; m_st[bk] = 1; m_row[bk] = row;
                  end else e.err = 1;
            3'd2, 3'd3: if (m_st[bk] == 1) begin
                      e.ok = 1; e.av = 1; e.col = {col[CW-1:2], 2'b00};
                      if (ap) begin m_st[bk] = 2; m_cnt[bk] = bl8 ? 4 : 2; end
                  end else e.err = 1;
            3'd4: begin e.ok = 1; if (m_st[bk] == 1) m_st[bk] = 0; end
            default: e.err = 1;
        endcase
        for (int b = 0; b < NB; b++) begin
            e.open[b] = (m_st[b] != 0);
            e.rows[b*RW +: RW] = m_row[b];
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic nop(input int n, input string tag);
        for (int i = 0; i < n; i++) issue(3'd0, 0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                bit bad;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                bad = (cmd_ok !== e.ok) || (cmd_err !== e.err) || (acc_valid !== e.av) ||
                      (bank_open !== e.open) || (ap_close !== e.close) ||
                      (e.av && acc_col !== e.col);
                for (int b = 0; b < NB; b++)
                    if (e.open[b] && open_rows[b*RW +: RW] !== e.rows[b*RW +: RW]) bad = 1;
                checks++;
                if (bad) begin
                    errors++;
                    $display("FAIL %s: got ok=%b err=%b av=%b col=%h open=%b close=%b rows=%h | exp ok=%b err=%b av=%b col=%h open=%b close=%b rows=%h",
                             t, cmd_ok, cmd_err, acc_valid, acc_col, bank_open, ap_close, open_rows,
                             e.ok, e.err, e.av, e.col, e.open, e.close, e.rows);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_row[b] = '0; m_cnt[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cmd_ok !== 0 || cmd_err !== 0 || acc_valid !== 0 || bank_open !== '0 || ap_close !== '0) begin
            errors++;
            $display("FAIL R1 reset: got ok=%b err=%b av=%b open=%b close=%b exp all zero",
                     cmd_ok, cmd_err, acc_valid, bank_open, ap_close);
        end

        issue(3'd1, 0, 12'h123, '0, 0, 0, "R2 activate bank0");
        issue(3'd2, 1, '0, 9'h010, 0, 0, "R4 read closed bank1");
        issue(3'd1, 0, 12'h555, '0, 0, 0, "R3 activate open bank0");
        issue(3'd1, 3, 12'hABC, '0, 0, 0, "R2 activate bank3");
        issue(3'd1, 7, 12'hFFF, '0, 0, 0, "R2 activate bank7 max row");
        issue(3'd2, 0, '0, 9'h1FF, 0, 0, "R5 read col masked");
        issue(3'd3, 7, '0, 9'h002, 0, 1, "R5 write col masked");
        issue(3'd0, 2, '0, '0, 0, 0, "R9 no-op");
        issue(3'd3, 3, '0, 9'h007, 1, 1, "R6 write ap bl8");
        issue(3'd1, 5, 12'h0F0, '0, 0, 0, "R8 activate during burst");
        issue(3'd2, 3, '0, '0, 0, 0, "R4 read auto-closing bank");
        issue(3'd1, 3, 12'h001, '0, 0, 0, "R3 activate auto-closing bank");
        issue(3'd4, 3, '0, '0, 0, 0, "R7 precharge auto-closing bank");
        nop(2, "R6 bl8 close");
        issue(3'd2, 0, '0, 9'h044, 1, 0, "R6 read ap bl4");
        nop(3, "R6 bl4 close");
        issue(3'd4, 0, '0, '0, 0, 0, "R7 precharge closed bank0");
        issue(3'd4, 5, '0, '0, 0, 0, "R7 precharge open bank5");
        issue(3'd5, 7, 12'h222, '0, 0, 0, "R9 reserved code 5");
        issue(3'd7, 2, 12'h333, '0, 0, 0, "R9 reserved code 7");
        issue(3'd2, 7, '0, 9'h0AB, 1, 0, "R6 read ap bl4 bank7");
        issue(3'd1, 0, 12'h777, '0, 0, 0, "R8 activate during close");
        issue(3'd3, 0, '0, 9'h103, 1, 1, "R6 write ap bl8 bank0");
        issue(3'd1, 7, 12'h0AA, '0, 0, 0, "R2 reopen after close");
        nop(5, "R6 drain");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule